// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block fills a 160-byte sprite attribute memory from a 256-byte page of the system address space. A CPU write to the trigger address 0xFF46 starts a transfer. The byte written selects the source page, so the copy reads addresses `{page, 0x00}` through `{page, 0x9F}`. The engine steps through the copy on a fixed cadence derived from one free-running transfer counter. The first step is a warm-up that moves nothing, each of the next 160 steps moves one byte, and one more step retires the engine.

The sprite memory sits inside the block and is reached by the CPU at 0xFE00–0xFE9F through a simple read/write port. Once a transfer is well under way, that port is fenced off: reads return 0xFF and writes are dropped. A double-speed input shortens each step from four clocks to two. The source side is a plain synchronous read port: an address and read strobe go out, and the byte is returned on the following cycle.

Top module: `obj_dma`

## Requirements
- R1: While reset is held and right after it, `busy` and `src_rd` are low and `cpu_rdata` reads 0xFF.
- R2: A CPU write to 0xFF46 raises `busy` on the next cycle with the transfer counter at 0. `busy` then stays high for 645 cycles at normal speed or 323 cycles at double speed.
- R3: Source reads occur only on step boundaries. A step boundary is counter mod 4 = 0 at normal speed and counter mod 2 = 0 at double speed. Step 0 issues no read, and exactly 160 reads are issued (steps 1..160). `busy` clears after step 161.
- R4: The read at step s (1..160) addresses `{page, s-1}`, with the latched page in bits 15:8. The returned byte is stored at sprite index s-1.
- R5: With no transfer running, a CPU write to 0xFE00+i (i < 160) stores at index i. A CPU read of that address returns the stored byte in `cpu_rdata` one cycle after `cpu_rd`. Reads of any other address return 0xFF.
- R6: While `busy` is high and the counter is at least 8, CPU reads of 0xFE00–0xFE9F return 0xFF.
- R7: While `busy` is high and the counter is at least 8, CPU writes to 0xFE00–0xFE9F leave the memory unchanged.
- R8: During the first 8 counter values of a transfer, CPU reads of sprite memory still return the stored contents.
- R9: A trigger write during a transfer restarts the transfer from step 0 with the new page. The final contents then come entirely from the new page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | 1 = double speed (2 clocks per step), 0 = 4 clocks per step |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid the cycle after `cpu_rd` |
| busy | output | 1 | Transfer in progress |
| src_rd | output | 1 | Source read strobe |
| src_addr | output | 16 | Source read address |
| src_data | input | 8 | Source read data, valid the cycle after `src_rd` |

## Verification
The properties assume that `fast_mode` holds steady for the whole of a transfer, because the step spacing and end-of-transfer count are only defined for one speed. They also assume that the source port answers every strobe on the next cycle. The bench changes `fast_mode` only while the engine is idle, and its source model registers a value computed from the address on every strobe. CPU accesses are placed at chosen counter values inside each transfer, so that both the open window (counter below 8) and the fenced window are exercised.

// File: rtl/obj_dma_pkg.sv
package obj_dma_pkg;
  // trigger register address: writing here starts a copy
  localparam logic [15:0] TRIG_ADDR  = 16'hFF46;
  // base of sprite attribute memory in the CPU map
  localparam logic [15:0] SPR_BASE   = 16'hFE00;
  // open-bus value returned for fenced or unmapped reads
  localparam logic [7:0]  OPEN_BUS   = 8'hFF;

  // log2 of clocks per step for a speed setting
  function automatic int unsigned step_shift(input logic fast);
    return fast ? 1 : 2;
  endfunction
endpackage

// File: rtl/obj_dma_seq.sv
module obj_dma_seq
  import obj_dma_pkg::*;
#(
  parameter int NUM_BYTES = 160,
  localparam int LAST_STEP = NUM_BYTES + 1,
  localparam int CW = $clog2((LAST_STEP + 1) * 4)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fast,
  input  logic          start,
  input  logic [7:0]    start_page,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic          rd_req,
  output logic [15:0]   rd_addr
);
  logic [7:0]    page_q;
  logic          at_step;
  logic [CW-1:0] step;
  logic [CW-1:0] step_m1;
  logic          copy_step;

  // step boundary and step index from the running counter
  always_comb begin
    if (fast) begin
      at_step = (cnt[0] == 1'b0);
      step    = cnt >> step_shift(1'b1);
    end else begin
      at_step = (cnt[1:0] == 2'b00);
      step    = cnt >> step_shift(1'b0);
    end
    step_m1   = step - CW'(1);
    copy_step = (step >= CW'(1)) && (step <= CW'(NUM_BYTES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      page_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      page_q <= start_page;
    end else if (active) begin
      cnt <= cnt + CW'(1);
      if (at_step && (step == CW'(LAST_STEP))) begin
        active <= 1'b0;
      end
    end
  end

  assign rd_req  = active && at_step && copy_step;
  assign rd_addr = {page_q, step_m1[7:0]};
endmodule

// File: rtl/obj_attr_ram.sv
module obj_attr_ram #(
  parameter int DEPTH = 160,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first registered output
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/obj_dma.sv
module obj_dma
  import obj_dma_pkg::*;
#(
  parameter int NUM_BYTES = 160,
  parameter int LOCK_AT   = 8,
  localparam int AW = $clog2(NUM_BYTES),
  localparam int CW = $clog2((NUM_BYTES + 2) * 4)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fast_mode,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        busy,
  output logic        src_rd,
  output logic [15:0] src_addr,
  input  logic [7:0]  src_data
);
  logic [CW-1:0] xfer_cnt;
  logic          trig;
  logic [15:0]   cpu_off;
  logic          in_spr;
  logic          fenced;
  logic          cpu_wr_ok;
  logic          fill_q;
  logic [AW-1:0] fill_idx_q;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_q;
  logic          open_q;

  assign trig      = cpu_wr && (cpu_addr == TRIG_ADDR);
  assign cpu_off   = cpu_addr - SPR_BASE;
  assign in_spr    = (cpu_addr >= SPR_BASE) && (cpu_off < 16'(NUM_BYTES));
  assign fenced    = busy && (xfer_cnt >= CW'(LOCK_AT));
  assign cpu_wr_ok = cpu_wr && in_spr && !fenced;

  obj_dma_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .fast      (fast_mode),
    .start     (trig),
    .start_page(cpu_wdata),
    .active    (busy),
    .cnt       (xfer_cnt),
    .rd_req    (src_rd),
    .rd_addr   (src_addr)
  );

  // one-cycle pipeline matching the source read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q     <= 1'b0;
      fill_idx_q <= '0;
    end else begin
      fill_q     <= src_rd;
      fill_idx_q <= src_addr[AW-1:0];
    end
  end

  // single write port: engine fill wins over CPU
  always_comb begin
    ram_we    = fill_q || cpu_wr_ok;
    ram_waddr = fill_q ? fill_idx_q : cpu_off[AW-1:0];
    ram_wdata = fill_q ? src_data   : cpu_wdata;
  end

  obj_attr_ram #(.DEPTH(NUM_BYTES), .DW(8)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (cpu_rd && in_spr),
    .raddr(cpu_off[AW-1:0]),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b1;
    end else if (cpu_rd) begin
      open_q <= !(in_spr && !fenced);
    end
  end

  assign cpu_rdata = open_q ? OPEN_BUS : ram_q;
endmodule

// File: rtl/obj_dma_chk.sv
module obj_dma_chk #(
  parameter int NUM_BYTES = 160,
  parameter int LOCK_AT   = 8,
  localparam int CW = $clog2((NUM_BYTES + 2) * 4)
) (
  input logic          clk,
  input logic          rst,
  input logic          fast_mode,
  input logic [15:0]   cpu_addr,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [7:0]    cpu_rdata,
  input logic          busy,
  input logic          src_rd,
  input logic [CW-1:0] cnt
);
  logic in_spr;
  assign in_spr = (cpu_addr >= 16'hFE00) && (cpu_addr < 16'hFE00 + 16'(NUM_BYTES));

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !src_rd));

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 16'hFF46) |=> (busy && cnt == '0));

  // R3
  src_gated_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> busy);

  // R3
  src_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd |=> !src_rd);

  // R3
  end_count_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == ($past(fast_mode) ? CW'((NUM_BYTES + 1) * 2)
                                                     : CW'((NUM_BYTES + 1) * 4))));

  // R6
  fenced_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && in_spr && busy && cnt >= CW'(LOCK_AT)) |=> (cpu_rdata == 8'hFF));
endmodule

bind obj_dma obj_dma_chk #(.NUM_BYTES(NUM_BYTES), .LOCK_AT(LOCK_AT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fast_mode(fast_mode),
  .cpu_addr (cpu_addr),
  .cpu_wr   (cpu_wr),
  .cpu_rd   (cpu_rd),
  .cpu_rdata(cpu_rdata),
  .busy     (busy),
  .src_rd   (src_rd),
  .cnt      (xfer_cnt)
);

// File: tb/obj_dma_bench.sv
`timescale 1ns/1ps
module obj_dma_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_mode = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        busy;
  logic        src_rd;
  logic [15:0] src_addr;
  logic [7:0]  src_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] shadow [160];

  always #2.5 clk = ~clk;

  obj_dma u_obj_dma (
    .clk(clk), .rst(rst), .fast_mode(fast_mode),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data)
  );

  function automatic logic [7:0] srcf(input logic [15:0] a);
    logic [7:0] hi, lo;
    hi = a[15:8];
    lo = a[7:0];
    return 8'(hi * 8'd7) + 8'(lo * 8'd13) + 8'd5;
  endfunction

  // source memory model: one cycle read latency
  always @(posedge clk) if (src_rd) src_data <= srcf(src_addr);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int actual, input int expected, input string msg);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, actual, expected);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
    cpu_rd = 1'b1; cpu_addr = a;
    tick();
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic readback(input string tag);
    int bad;
    logic [7:0] d;
    bad = 0;
    for (int i = 0; i < 160; i++) begin
      cpu_read(16'hFE00 + 16'(i), d);
      if (d !== shadow[i]) begin
        if (bad == 0) $display("FAIL %s: index %0d actual=%0h expected=%0h", tag, i, d, shadow[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  task automatic run_xfer(input logic [7:0] page, input logic fast, input string tag);
    int per, last_n, n_src, bad_seq, bad_busy, stp;
    logic exp_rd;
    logic [15:0] exp_addr;
    logic [7:0] d;
    fast_mode = fast;
    per = fast ? 2 : 4;
    last_n = 161 * per;
    n_src = 0; bad_seq = 0; bad_busy = 0;
    cpu_write(16'hFF46, page);
    for (int n = 0; n <= last_n + 1; n++) begin
      stp = n / per;
      exp_rd = ((n % per) == 0) && (stp >= 1) && (stp <= 160);
      exp_addr = {page, 8'(stp - 1)};
      if (busy !== (n <= last_n)) bad_busy++;
      if ((src_rd !== exp_rd) || (exp_rd && (src_addr !== exp_addr))) begin
        if (bad_seq == 0)
          $display("FAIL %s R3/R4: n=%0d src_rd=%0b addr=%0h expected rd=%0b addr=%0h",
                   tag, n, src_rd, src_addr, exp_rd, exp_addr);
        bad_seq++;
      end
      if (src_rd === 1'b1) n_src++;
      if (n == 3)  check(cpu_rdata, shadow[5], {tag, " R8 early read"});
      if (n == 21) check(cpu_rdata, 8'hFF, {tag, " R6 fenced read"});
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      if (n == 2)  begin cpu_rd = 1'b1; cpu_addr = 16'hFE05; end
      if (n == 20) begin cpu_rd = 1'b1; cpu_addr = 16'hFE96; end
      if (n == 30) begin cpu_wr = 1'b1; cpu_addr = 16'hFE00; cpu_wdata = 8'h5A; end
      tick();
    end
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    check(bad_busy, 0, {tag, " R2 busy length"});
    check(bad_seq, 0, {tag, " R3 R4 step cadence and address"});
    check(n_src, 160, {tag, " R3 read count"});
    for (int i = 0; i < 160; i++) shadow[i] = srcf({page, 8'(i)});
    cpu_read(16'hFE00, d);
    check(d, srcf({page, 8'h00}), {tag, " R7 fenced write dropped"});
    readback({tag, " R4 contents"});
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    // R1
    check(busy, 0, "R1 busy in reset");
    check(src_rd, 0, "R1 src_rd in reset");
    rst = 1'b0;
    tick();
    check(cpu_rdata, 8'hFF, "R1 rdata after reset");
    check(busy, 0, "R1 busy after reset");

    // R5: idle sweep of the CPU port
    for (int i = 0; i < 160; i++) begin
      shadow[i] = 8'(i) ^ 8'hA5;
      cpu_write(16'hFE00 + 16'(i), shadow[i]);
    end
    readback("R5 idle sweep");
    cpu_read(16'hFEA0, d);
    check(d, 8'hFF, "R5 past end reads open");
    cpu_read(16'h1234, d);
    check(d, 8'hFF, "R5 unmapped reads open");

    run_xfer(8'h12, 1'b0, "normal 12");
    run_xfer(8'h00, 1'b0, "normal 00");
    run_xfer(8'hFF, 1'b0, "normal FF");
    run_xfer(8'h80, 1'b1, "fast 80");
    run_xfer(8'h3C, 1'b1, "fast 3C");

    // R9: restart part way through
    fast_mode = 1'b0;
    cpu_write(16'hFF46, 8'h33);
    repeat (100) tick();
    check(busy, 1, "R9 busy before restart");
    for (int k = 0; k < 24; k++) shadow[k] = srcf({8'h33, 8'(k)});
    run_xfer(8'h44, 1'b0, "R9 restart 44");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule